// File: doc/BRIEF.md
# Dual Calendar Alarm with Interrupt Routing

This block watches a BCD calendar and raises alarms. It holds two alarm settings. Each setting is compared against the current time once per second, on the cycle in which the one-second tick is high. The time counters have already advanced to the new second in that cycle. Each alarm register carries a mask bit that removes its field from the comparison. The day/date registers also carry a select bit that picks between day of week and date of month. A hit sets a sticky flag, and software clears the flag by writing zero to it.

The flags, gated by their enables, drive two active-low interrupt lines. Two control bits decide the routing: a routing-select bit, and an external-clock-enable bit that turns line A into a clock input. When routing-select is 0, line B passes an externally generated square wave. The second alarm has no seconds field, so it can only fire at second 00. All settings are written through a small register port with a write strobe.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset all alarm registers, the control register and the status register are zero. Both flags are 0, irq_a_n is 1, a_drive is 1 and irq_b_n follows sqw_in.
- R2: Alarm 1 uses addresses 0 (seconds), 1 (minutes), 2 (hours) and 3 (day/date). Bit 7 of each register is the mask bit, and a set mask removes that field from the comparison. Masks 1111 fire on every tick, 1110 on a seconds match, 1100 on minutes and seconds, and 1000 on hours, minutes and seconds. Seconds and minutes compare bits 6..0.
- R3: In a day/date alarm register, bit 6 selects the field and bits 5..0 hold the value. With all alarm 1 masks 0, bit 6 = 0 compares the value with t_date[5:0] and bit 6 = 1 compares it with t_dow[5:0], in both cases together with hours, minutes and seconds.
- R4: Alarm 2 uses addresses 4 (minutes), 5 (hours) and 6 (day/date), with the same mask and select bits. It can fire only when t_sec is 8'h00. Masks 111 fire every minute, 110 on a minutes match, 100 on hours and minutes, and 000 adds the day or date field.
- R5: Hours compare bits 6..0 of the stored byte, so the 12/24 mode bit and the AM/PM bit must also be equal.
- R6: Comparison takes place only in a cycle with tick high. A resulting flag is visible on the next cycle. A matching time with tick low sets nothing.
- R7: A hit sets its flag (flag1 for alarm 1, flag2 for alarm 2) whatever the state of the interrupt enables.
- R8: The status register is at address 8, with bit 0 = flag1, bit 1 = flag2 and bit 2 = external-clock enable. Writing 0 to a flag bit clears that flag. Writing 1 leaves it unchanged. A hit in the same cycle as a clearing write leaves the flag set.
- R9: The control register is at address 7, with bit 0 = alarm 1 enable, bit 1 = alarm 2 enable and bit 2 = routing select. With routing select 0 and external clock 0, irq_a_n is low exactly when an enabled flag is set, and irq_b_n equals sqw_in.
- R10: With routing select 0 and external clock 1, a_drive is 0, irq_a_n stays high and irq_b_n equals sqw_in.
- R11: With routing select 1 and external clock 0, irq_a_n is low exactly when flag1 and its enable are set. irq_b_n is low exactly when flag2 and its enable are set.
- R12: With routing select 1 and external clock 1, a_drive is 0 and irq_a_n stays high. irq_b_n is low exactly when an enabled flag is set.
- R13: Writes to addresses 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse marking a new second |
| t_sec | input | 8 | Current seconds, BCD |
| t_min | input | 8 | Current minutes, BCD |
| t_hour | input | 8 | Current hours byte including mode bits |
| t_dow | input | 8 | Current day of week |
| t_date | input | 8 | Current date of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| sqw_in | input | 1 | Square wave passed to line B |
| flag1 | output | 1 | Sticky alarm 1 flag |
| flag2 | output | 1 | Sticky alarm 2 flag |
| irq_a_n | output | 1 | Interrupt line A, active low |
| irq_b_n | output | 1 | Interrupt line B, active low, or square wave |
| a_drive | output | 1 | 1 while line A acts as an output |

## Verification
The assertions assume that tick is a single-cycle pulse and that the time inputs are stable in the cycle tick is high. They also assume that wr_addr, wr_data and the time inputs hold defined values from reset onward. The bench changes time values and the tick only at falling edges. It raises tick for exactly one cycle per tick task and never leaves an input undriven. It avoids a date value of 0, so the zeroed reset alarm settings never match by accident.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int A1_FIELDS = 4;
  localparam int A2_FIELDS = 3;
  localparam int A1_BASE   = 0;
  localparam int A2_BASE   = A1_BASE + A1_FIELDS;
  localparam int CTRL_ADDR = A2_BASE + A2_FIELDS;
  localparam int STAT_ADDR = CTRL_ADDR + 1;

  localparam int MASK_BIT  = 7;
  localparam int SEL_BIT   = 6;

  localparam int CB_EN1    = 0;
  localparam int CB_EN2    = 1;
  localparam int CB_ROUTE  = 2;
  localparam int SB_F1     = 0;
  localparam int SB_F2     = 1;
  localparam int SB_EXT    = 2;

  typedef enum logic [1:0] {
    RT_SHARED_SQW = 2'b00,
    RT_INPUT_SQW  = 2'b01,
    RT_SPLIT      = 2'b10,
    RT_INPUT_BOTH = 2'b11
  } route_e;

  function automatic logic field_hit(input logic [DATA_W-1:0] areg,
                                     input logic [6:0] tval);
    return areg[MASK_BIT] | (areg[6:0] == tval);
  endfunction

  function automatic logic dd_hit(input logic [DATA_W-1:0] areg,
                                  input logic [DATA_W-1:0] dow,
                                  input logic [DATA_W-1:0] date);
    logic [5:0] pick;
    pick = areg[SEL_BIT] ? dow[5:0] : date[5:0];
    return areg[MASK_BIT] | (areg[5:0] == pick);
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               set1,
  input  logic                               set2,
  output logic [A1_FIELDS-1:0][DATA_W-1:0]   a1_q,
  output logic [A2_FIELDS-1:0][DATA_W-1:0]   a2_q,
  output logic                               en1,
  output logic                               en2,
  output logic                               route_sel,
  output logic                               ext_en,
  output logic                               flag1,
  output logic                               flag2,
  output logic                               clr1_ev,
  output logic                               clr2_ev
);
  logic stat_wr, ctrl_wr;

  assign stat_wr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign clr1_ev = stat_wr && !wr_data[SB_F1];
  assign clr2_ev = stat_wr && !wr_data[SB_F2];

  genvar gi;
  generate
    for (gi = 0; gi < A1_FIELDS; gi++) begin : g_a1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          a1_q[gi] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(A1_BASE + gi))
          a1_q[gi] <= wr_data;
      end
    end
    for (gi = 0; gi < A2_FIELDS; gi++) begin : g_a2
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          a2_q[gi] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(A2_BASE + gi))
          a2_q[gi] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1       <= 1'b0;
      en2       <= 1'b0;
      route_sel <= 1'b0;
    end else if (ctrl_wr) begin
      en1       <= wr_data[CB_EN1];
      en2       <= wr_data[CB_EN2];
      route_sel <= wr_data[CB_ROUTE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ext_en <= 1'b0;
    else if (stat_wr)
      ext_en <= wr_data[SB_EXT];
  end

  // Set wins over a clearing write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag1 <= 1'b0;
      flag2 <= 1'b0;
    end else begin
      flag1 <= set1 | (flag1 & ~clr1_ev);
      flag2 <= set2 | (flag2 & ~clr2_ev);
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1,
  localparam int NF     = HAS_SEC ? 4 : 3,
  localparam int OFS    = HAS_SEC ? 1 : 0
)(
  input  logic [NF-1:0][DATA_W-1:0] areg,
  input  logic [DATA_W-1:0]         t_sec,
  input  logic [DATA_W-1:0]         t_min,
  input  logic [DATA_W-1:0]         t_hour,
  input  logic [DATA_W-1:0]         t_dow,
  input  logic [DATA_W-1:0]         t_date,
  output logic                      hit
);
  logic sec_ok, min_ok, hour_ok, dd_ok;

  generate
    if (HAS_SEC) begin : g_sec
      assign sec_ok = field_hit(areg[0], t_sec[6:0]);
    end else begin : g_nosec
      assign sec_ok = (t_sec == '0);
    end
  endgenerate

  assign min_ok  = field_hit(areg[OFS],     t_min[6:0]);
  assign hour_ok = field_hit(areg[OFS + 1], t_hour[6:0]);
  assign dd_ok   = dd_hit(areg[OFS + 2], t_dow, t_date);
  assign hit     = sec_ok & min_ok & hour_ok & dd_ok;
endmodule

// File: rtl/irq_route.sv
module irq_route
  import alarm_pkg::*;
(
  input  logic flag1,
  input  logic flag2,
  input  logic en1,
  input  logic en2,
  input  logic route_sel,
  input  logic ext_en,
  input  logic sqw_in,
  output logic irq_a_n,
  output logic irq_b_n,
  output logic a_drive
);
  logic act1, act2;
  route_e mode;

  assign act1 = flag1 & en1;
  assign act2 = flag2 & en2;
  assign mode = route_e'({route_sel, ext_en});

  always_comb begin
    irq_a_n = 1'b1;
    irq_b_n = sqw_in;
    a_drive = 1'b1;
    unique case (mode)
      RT_SHARED_SQW: irq_a_n = ~(act1 | act2);
      RT_INPUT_SQW:  a_drive = 1'b0;
      RT_SPLIT: begin
        irq_a_n = ~act1;
        irq_b_n = ~act2;
      end
      RT_INPUT_BOTH: begin
        a_drive = 1'b0;
        irq_b_n = ~(act1 | act2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [7:0]        t_sec,
  input  logic [7:0]        t_min,
  input  logic [7:0]        t_hour,
  input  logic [7:0]        t_dow,
  input  logic [7:0]        t_date,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sqw_in,
  output logic              flag1,
  output logic              flag2,
  output logic              irq_a_n,
  output logic              irq_b_n,
  output logic              a_drive
);
  logic [A1_FIELDS-1:0][DATA_W-1:0] a1_q;
  logic [A2_FIELDS-1:0][DATA_W-1:0] a2_q;
  logic en1, en2, route_sel, ext_en;
  logic hit1, hit2, ev_set1, ev_set2, clr1_ev, clr2_ev;

  assign ev_set1 = tick & hit1;
  assign ev_set2 = tick & hit2;

  alarm_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set1(ev_set1), .set2(ev_set2), .a1_q(a1_q), .a2_q(a2_q),
    .en1(en1), .en2(en2), .route_sel(route_sel), .ext_en(ext_en),
    .flag1(flag1), .flag2(flag2), .clr1_ev(clr1_ev), .clr2_ev(clr2_ev)
  );

  alarm_match #(.HAS_SEC(1'b1)) u_m1 (
    .areg(a1_q), .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
    .t_dow(t_dow), .t_date(t_date), .hit(hit1)
  );

  alarm_match #(.HAS_SEC(1'b0)) u_m2 (
    .areg(a2_q), .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
    .t_dow(t_dow), .t_date(t_date), .hit(hit2)
  );

  irq_route u_route (
    .flag1(flag1), .flag2(flag2), .en1(en1), .en2(en2),
    .route_sel(route_sel), .ext_en(ext_en), .sqw_in(sqw_in),
    .irq_a_n(irq_a_n), .irq_b_n(irq_b_n), .a_drive(a_drive)
  );
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [7:0] t_sec,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       sqw_in,
  input logic       flag1,
  input logic       flag2,
  input logic       irq_a_n,
  input logic       irq_b_n,
  input logic       a_drive,
  input logic       route_sel,
  input logic       hit2,
  input logic       ev_set1,
  input logic       ev_set2
);
  a_r6_flag1_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag1) |-> $past(tick));
  a_r6_flag2_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag2) |-> $past(tick));
  a_r7_set1_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set1 |=> flag1);
  a_r7_set2_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set2 |=> flag2);
  a_r8_clear1_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag1) |-> $past(wr_en && wr_addr == 4'd8 && !wr_data[0]));
  a_r8_clear2_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag2) |-> $past(wr_en && wr_addr == 4'd8 && !wr_data[1]));
  a_r4_sec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit2 |-> (t_sec == 8'h00));
  a_r10_a_released: assert property (@(posedge clk) disable iff (!rst_n)
    !a_drive |-> irq_a_n);
  a_r9_b_square: assert property (@(posedge clk) disable iff (!rst_n)
    !route_sel |-> (irq_b_n == sqw_in));
  a_r1_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag1 && !flag2) |-> irq_a_n);
endmodule

bind alarm_irq_top alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .t_sec(t_sec),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sqw_in(sqw_in),
  .flag1(flag1), .flag2(flag2), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n),
  .a_drive(a_drive), .route_sel(route_sel), .hit2(hit2),
  .ev_set1(ev_set1), .ev_set2(ev_set2)
);

// File: tb/alarm_irq_top_tb.sv
module alarm_irq_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] t_sec = 8'h00, t_min = 8'h00, t_hour = 8'h00, t_dow = 8'h01, t_date = 8'h01;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic sqw_in = 1'b0;
  logic flag1, flag2, irq_a_n, irq_b_n, a_drive;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  alarm_irq_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .t_sec(t_sec), .t_min(t_min),
    .t_hour(t_hour), .t_dow(t_dow), .t_date(t_date), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sqw_in(sqw_in), .flag1(flag1),
    .flag2(flag2), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n), .a_drive(a_drive)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt);
    t_sec = s; t_min = m; t_hour = h; t_dow = dw; t_date = dt;
  endtask

  task automatic do_tick(input logic [7:0] s, m, h, dw, dt);
    @(negedge clk);
    set_time(s, m, h, dw, dt);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clear_flags();
    wr(4'd8, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 flag1", flag1, 1'b0);
    chk("R1 flag2", flag2, 1'b0);
    chk("R1 irq_a_n", irq_a_n, 1'b1);
    chk("R1 a_drive", a_drive, 1'b1);
    sqw_in = 1'b1; #1;
    chk("R1 irq_b_n follows sqw high", irq_b_n, 1'b1);
    sqw_in = 1'b0; #1;
    chk("R1 irq_b_n follows sqw low", irq_b_n, 1'b0);
  endtask

  task automatic t_a1_masks();
    wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
    do_tick(8'h37, 8'h12, 8'h05, 8'h02, 8'h09);
    chk("R2 mask 1111 every tick", flag1, 1'b1);
    chk("R7 flag1 with enable off", flag1, 1'b1);
    clear_flags();
    wr(4'd0, 8'h25);
    do_tick(8'h24, 8'h12, 8'h05, 8'h02, 8'h09);
    chk("R2 mask 1110 sec mismatch", flag1, 1'b0);
    do_tick(8'h25, 8'h12, 8'h05, 8'h02, 8'h09);
    chk("R2 mask 1110 sec match", flag1, 1'b1);
    clear_flags();
    wr(4'd1, 8'h10);
    do_tick(8'h25, 8'h11, 8'h05, 8'h02, 8'h09);
    chk("R2 mask 1100 min mismatch", flag1, 1'b0);
    do_tick(8'h25, 8'h10, 8'h05, 8'h02, 8'h09);
    chk("R2 mask 1100 match", flag1, 1'b1);
    clear_flags();
    wr(4'd2, 8'h08);
    do_tick(8'h25, 8'h10, 8'h09, 8'h02, 8'h09);
    chk("R2 mask 1000 hour mismatch", flag1, 1'b0);
    do_tick(8'h25, 8'h10, 8'h08, 8'h02, 8'h09);
    chk("R2 mask 1000 match", flag1, 1'b1);
    clear_flags();
  endtask

  task automatic t_tick_only();
    // alarm 1 still 1000 on 08:10:25: matching time with tick low
    @(negedge clk);
    set_time(8'h25, 8'h10, 8'h08, 8'h02, 8'h09);
    repeat (4) @(negedge clk);
    chk("R6 no tick no flag", flag1, 1'b0);
    @(negedge clk); tick = 1'b1;
    #1 chk("R6 flag not set within tick cycle", flag1, 1'b0);
    @(negedge clk); tick = 1'b0;
    chk("R6 flag next cycle", flag1, 1'b1);
    clear_flags();
  endtask

  task automatic t_a1_daydate();
    wr(4'd0, 8'h00); wr(4'd1, 8'h30); wr(4'd2, 8'h12); wr(4'd3, 8'h15);
    do_tick(8'h00, 8'h30, 8'h12, 8'h03, 8'h16);
    chk("R3 date mismatch", flag1, 1'b0);
    do_tick(8'h00, 8'h30, 8'h12, 8'h03, 8'h15);
    chk("R3 date match", flag1, 1'b1);
    clear_flags();
    wr(4'd3, 8'h43);
    do_tick(8'h00, 8'h30, 8'h12, 8'h04, 8'h03);
    chk("R3 day mismatch (date equals value)", flag1, 1'b0);
    do_tick(8'h00, 8'h30, 8'h12, 8'h03, 8'h20);
    chk("R3 day match", flag1, 1'b1);
    clear_flags();
  endtask

  task automatic t_hours_mode();
    wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h52); wr(4'd3, 8'h80);
    do_tick(8'h01, 8'h00, 8'h72, 8'h01, 8'h01);
    chk("R5 pm bit differs", flag1, 1'b0);
    do_tick(8'h01, 8'h00, 8'h12, 8'h01, 8'h01);
    chk("R5 12/24 bit differs", flag1, 1'b0);
    do_tick(8'h01, 8'h00, 8'h52, 8'h01, 8'h01);
    chk("R5 full hour byte match", flag1, 1'b1);
    clear_flags();
    wr(4'd2, 8'h7F); // park alarm 1 on an impossible hour
  endtask

  task automatic t_a2();
    wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
    do_tick(8'h01, 8'h05, 8'h05, 8'h01, 8'h01);
    chk("R4 111 not at sec 01", flag2, 1'b0);
    do_tick(8'h00, 8'h05, 8'h05, 8'h01, 8'h01);
    chk("R4 111 at sec 00", flag2, 1'b1);
    clear_flags();
    wr(4'd4, 8'h45);
    do_tick(8'h10, 8'h45, 8'h05, 8'h01, 8'h01);
    chk("R4 110 min match wrong sec", flag2, 1'b0);
    do_tick(8'h00, 8'h44, 8'h05, 8'h01, 8'h01);
    chk("R4 110 min mismatch", flag2, 1'b0);
    do_tick(8'h00, 8'h45, 8'h05, 8'h01, 8'h01);
    chk("R4 110 match", flag2, 1'b1);
    clear_flags();
    wr(4'd5, 8'h23); wr(4'd6, 8'h45); // day 5
    do_tick(8'h00, 8'h45, 8'h23, 8'h04, 8'h05);
    chk("R4 000 day mismatch", flag2, 1'b0);
    do_tick(8'h00, 8'h45, 8'h23, 8'h05, 8'h11);
    chk("R4 000 day match", flag2, 1'b1);
    clear_flags();
  endtask

  task automatic t_clear();
    wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
    wr(4'd2, 8'h80);
    do_tick(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    chk("R8 setup flag1", flag1, 1'b1);
    chk("R8 setup flag2", flag2, 1'b1);
    wr(4'd8, 8'h03);
    chk("R8 write 1 keeps flag1", flag1, 1'b1);
    chk("R8 write 1 keeps flag2", flag2, 1'b1);
    wr(4'd8, 8'h02);
    chk("R8 write 0 clears flag1", flag1, 1'b0);
    chk("R8 flag2 untouched", flag2, 1'b1);
    // clearing write and hit in the same cycle
    @(negedge clk);
    set_time(8'h07, 8'h00, 8'h00, 8'h01, 8'h01);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h00;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R8 set wins over clear", flag1, 1'b1);
    chk("R8 flag2 cleared (no hit at sec 07)", flag2, 1'b0);
    for (int a = 9; a < 16; a++) wr(4'(a), 8'h00);
    chk("R13 unmapped writes keep flag1", flag1, 1'b1);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_steer();
    do_tick(8'h00, 8'h00, 8'h00, 8'h01, 8'h01); // both alarms fully masked
    chk("R7 both flags with enables off", flag1 & flag2, 1'b1);
    chk("R9 enables off A high", irq_a_n, 1'b1);
    wr(4'd7, 8'h01); wr(4'd8, 8'h03);
    chk("R9 en1 A low", irq_a_n, 1'b0);
    sqw_in = 1'b1; #1;
    chk("R9 B is sqw", irq_b_n, 1'b1);
    wr(4'd8, 8'h07);
    chk("R10 a_drive off", a_drive, 1'b0);
    chk("R10 A released", irq_a_n, 1'b1);
    sqw_in = 1'b0; #1;
    chk("R10 B is sqw", irq_b_n, 1'b0);
    wr(4'd7, 8'h06); wr(4'd8, 8'h03);
    chk("R11 a_drive on", a_drive, 1'b1);
    chk("R11 A needs en1", irq_a_n, 1'b1);
    chk("R11 B shows flag2", irq_b_n, 1'b0);
    wr(4'd7, 8'h05);
    chk("R11 A shows flag1", irq_a_n, 1'b0);
    chk("R11 B needs en2", irq_b_n, 1'b1);
    wr(4'd8, 8'h07);
    chk("R12 a_drive off", a_drive, 1'b0);
    chk("R12 A released", irq_a_n, 1'b1);
    chk("R12 B shows OR", irq_b_n, 1'b0);
    wr(4'd8, 8'h06); // clear flag1, ext stays on
    chk("R12 B high when only disabled flag2", irq_b_n, 1'b1);
    wr(4'd7, 8'h03); wr(4'd8, 8'h02);
    chk("R9 A low from flag2 alone", irq_a_n, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_a1_masks();
    t_tick_only();
    t_a1_daydate();
    t_hours_mode();
    t_a2();
    t_clear();
    t_steer();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule